// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a 32-bit processor that finishes every instruction in exactly one clock cycle. It supports four instruction kinds. Register-type instructions do add, subtract, and, or and signed set-less-than. Load word and store word use base-plus-offset addressing. Branch-if-equal is PC-relative. The fields sit at fixed bit positions. The opcode is bits 31:26, rs is 25:21, rt is 20:16, rd is 15:11, the function field is 5:0 and the 16-bit immediate is 15:0. Opcodes are 000000 for register-type, 100011 for load, 101011 for store and 000100 for branch-if-equal.

Decoding happens in two levels. The first decoder reads the opcode and sets the datapath steering and enables. It also emits a 2-bit ALU category: 00 always adds, 01 always subtracts, and 10 defers to the function field. The second decoder turns the category and the function field into a 4-bit ALU code. The instruction memory and the data memory are word-addressed and held inside the core. They are filled through a preload port while reset is held.

The core drives a trace of each cycle's effects on its outputs. This trace gives the current PC, the register write-back (enable, index and value) and the data-memory write (enable, byte address and value).

Top module: `sc_core`

## Requirements
- R1: While reset is high at a rising edge, the PC becomes 0. The register and memory write enables on the trace outputs stay 0 for as long as reset is high.
- R2: A load (opcode 100011) writes register rt with the data word at byte address rs + sign-extended immediate.
- R3: A store (opcode 101011) writes the value of rt to byte address rs + sign-extended immediate and does not write a register. A later load from that address returns the stored word.
- R4: A register-type instruction (opcode 000000) writes register rd with rs op rt. The function field selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or.
- R5: Function 0x2A writes 1 to rd when rs is less than rt as signed numbers, and 0 otherwise.
- R6: For loads and stores the ALU adds, whatever value the low six immediate bits hold, even when they equal a register-type function code.
- R7: Branch-if-equal (opcode 000100) writes nothing. When rs equals rt the next PC is PC+4 + (sign-extended immediate << 2). When they differ it is PC+4.
- R8: Register 0 reads as zero. A write aimed at it still appears on the trace but leaves its value at zero.
- R9: Any other opcode writes nothing and advances the PC by 4.
- R10: A result is written at the edge that ends its instruction's cycle, so the very next instruction reads the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Preload write strobe |
| pre_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| pre_addr | input | MEM_AW | Preload word index |
| pre_data | input | 32 | Preload word |
| pc_o | output | 32 | Current PC (byte address) |
| rf_we_o | output | 1 | Register write-back this cycle |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data-memory write this cycle |
| dm_addr_o | output | 32 | Data-memory byte address |
| dm_wdata_o | output | 32 | Data-memory write value |

## Verification
Write-back of one instruction and operand read by the next meet at a single clock edge. The program therefore places each consumer directly after its producer. A load is followed by a register-type instruction that uses the loaded register. A load is followed by a branch that compares the loaded value. A write to register 0 is followed by an add of register 0 to itself. The consumer's trace value is compared with the value computed from the requirements. Any stale operand, or any forwarding of a register 0 write, changes that value or the branch outcome seen on the PC.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int REG_AW = $clog2(NREG);

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        CAT_ADDR = 2'b00,
        CAT_CMP  = 2'b01,
        CAT_FUNC = 2'b10
    } alu_cat_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_op_e;

    typedef struct packed {
        logic     dst_rd;
        logic     src_imm;
        logic     wb_mem;
        logic     reg_we;
        logic     mem_rd;
        logic     mem_wr;
        logic     branch;
        alu_cat_e cat;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl     = '0;
        ctrl.cat = CAT_ADDR;
        case (opcode)
            OPC_REG: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.cat    = CAT_FUNC;
            end
            OPC_LOAD: begin
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.cat    = CAT_CMP;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
    import sc_pkg::*;
(
    input  alu_cat_e   cat,
    input  logic [5:0] funct,
    output alu_op_e    op
);
    always_comb begin
        op = ALU_ADD;
        case (cat)
            CAT_ADDR: op = ALU_ADD;
            CAT_CMP:  op = ALU_SUB;
            CAT_FUNC: begin
                case (funct)
                    FN_ADD:  op = ALU_ADD;
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: op = ALU_ADD;
                endcase
            end
            default: op = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_NOR: y = ~(a | b);
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int N  = 32,
    parameter int W  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs [1:N-1];

    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic              pre_dmem,
    input  logic [MEM_AW-1:0] pre_addr,
    input  logic [XLEN-1:0]   pre_data,
    output logic [XLEN-1:0]   pc_o,
    output logic              rf_we_o,
    output logic [REG_AW-1:0] rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o,
    output logic              dm_we_o,
    output logic [XLEN-1:0]   dm_addr_o,
    output logic [XLEN-1:0]   dm_wdata_o
);
    localparam int MEM_WORDS = 1 << MEM_AW;

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_plus4, br_target, instr;
    logic [XLEN-1:0] imm_ext, rs_data, rt_data, alu_b, alu_y, mem_q, wb_data;
    logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, dst_idx;
    logic            alu_zero, take_br, rf_we, dm_we;
    ctrl_t           ctrl;
    alu_op_e         alu_op;

    assign instr   = imem[pc_q[MEM_AW+1:2]];
    assign rs_idx  = instr[25:21];
    assign rt_idx  = instr[20:16];
    assign rd_idx  = instr[15:11];
    assign imm_ext = sext16(instr[15:0]);

    sc_main_dec u_mdec (.opcode(instr[31:26]), .ctrl(ctrl));
    sc_alu_dec  u_adec (.cat(ctrl.cat), .funct(instr[5:0]), .op(alu_op));

    sc_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk(clk), .we(rf_we), .wa(dst_idx), .wd(wb_data),
        .ra1(rs_idx), .ra2(rt_idx), .rd1(rs_data), .rd2(rt_data)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rt_data;

    sc_alu #(.W(XLEN)) u_alu (
        .a(rs_data), .b(alu_b), .op(alu_op), .y(alu_y), .zero(alu_zero)
    );

    assign mem_q   = dmem[alu_y[MEM_AW+1:2]];
    assign wb_data = ctrl.wb_mem ? mem_q : alu_y;
    assign dst_idx = ctrl.dst_rd ? rd_idx : rt_idx;
    assign rf_we   = ctrl.reg_we & ~rst;
    assign dm_we   = ctrl.mem_wr & ~rst;

    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign take_br   = ctrl.branch & alu_zero;

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= '0;
        else if (take_br) pc_q <= br_target;
        else              pc_q <= pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (pre_we && !pre_dmem) imem[pre_addr] <= pre_data;
    end

    always_ff @(posedge clk) begin
        if (pre_we && pre_dmem) dmem[pre_addr] <= pre_data;
        else if (dm_we)         dmem[alu_y[MEM_AW+1:2]] <= rt_data;
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = dst_idx;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_data;

    logic unused_bits;
    assign unused_bits = ^{pc_q[XLEN-1:MEM_AW+2], pc_q[1:0],
                           alu_y[1:0], instr[10:6], ctrl.mem_rd};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc_q,
    input logic              take_br,
    input logic [XLEN-1:0]   br_target,
    input ctrl_t             ctrl,
    input logic [REG_AW-1:0] rs_idx,
    input logic [XLEN-1:0]   rs_data,
    input logic              rf_we_o,
    input logic              dm_we_o
);
    p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc_q == '0))
        else $error("reset did not clear PC");

    p_mem_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.mem_rd && ctrl.mem_wr))
        else $error("read and write enables both set");

    p_store_norf_r3: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o)
        else $error("store also wrote a register");

    p_taken_r7: assert property (@(posedge clk) disable iff (rst)
        take_br |=> (pc_q == $past(br_target)))
        else $error("taken branch went elsewhere");

    p_seq_pc_r9: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> (pc_q == $past(pc_q) + 32'd4))
        else $error("PC did not step by 4");

    p_r0_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == '0) |-> (rs_data == '0))
        else $error("register 0 read nonzero");
endmodule

bind sc_core sc_core_chk u_chk (
    .clk(clk), .rst(rst), .pc_q(pc_q), .take_br(take_br),
    .br_target(br_target), .ctrl(ctrl), .rs_idx(rs_idx),
    .rs_data(rs_data), .rf_we_o(rf_we_o), .dm_we_o(dm_we_o)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;
    localparam int CLK_P  = 10;
    localparam int MEM_AW = 6;
    localparam int NPROG  = 20;
    localparam int NROW   = 19;

    typedef struct packed {
        logic [31:0] pc;
        logic        rfwe;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic        dmwe;
        logic [31:0] da;
        logic [31:0] dd;
    } row_t;

    // word index = PC/4
    localparam logic [31:0] PROG [NPROG] = '{
        32'h8C010000,  // 0  lw  r1,0(r0)
        32'h8C020004,  // 4  lw  r2,4(r0)
        32'h00221820,  // 8  add r3,r1,r2
        32'h00222022,  // 12 sub r4,r1,r2
        32'h00222824,  // 16 and r5,r1,r2
        32'h00223025,  // 20 or  r6,r1,r2
        32'h0041382A,  // 24 slt r7,r2,r1
        32'h0022402A,  // 28 slt r8,r1,r2
        32'hAC04000C,  // 32 sw  r4,12(r0)
        32'h8C89FFF8,  // 36 lw  r9,-8(r4)
        32'h10290002,  // 40 beq r1,r9,+2
        32'h00215020,  // 44 add r10 (skipped)
        32'hAC020000,  // 48 sw  r2,0(r0) (skipped)
        32'h10220005,  // 52 beq r1,r2,+5
        32'h00210020,  // 56 add r0,r1,r1
        32'h00005820,  // 60 add r11,r0,r0
        32'hAC830024,  // 64 sw  r3,0x24(r4)
        32'hFC000000,  // 68 unsupported opcode
        32'h8C0C000C,  // 72 lw  r12,12(r0)
        32'h1000FFFF   // 76 beq r0,r0,-1
    };

    localparam row_t ROWS [NROW] = '{
        '{32'd0,  1'b1, 5'd1,  32'd5,        1'b0, 32'd0,  32'd0},
        '{32'd4,  1'b1, 5'd2,  32'hFFFFFFFD, 1'b0, 32'd0,  32'd0},
        '{32'd8,  1'b1, 5'd3,  32'd2,        1'b0, 32'd0,  32'd0},
        '{32'd12, 1'b1, 5'd4,  32'd8,        1'b0, 32'd0,  32'd0},
        '{32'd16, 1'b1, 5'd5,  32'd5,        1'b0, 32'd0,  32'd0},
        '{32'd20, 1'b1, 5'd6,  32'hFFFFFFFD, 1'b0, 32'd0,  32'd0},
        '{32'd24, 1'b1, 5'd7,  32'd1,        1'b0, 32'd0,  32'd0},
        '{32'd28, 1'b1, 5'd8,  32'd0,        1'b0, 32'd0,  32'd0},
        '{32'd32, 1'b0, 5'd0,  32'd0,        1'b1, 32'd12, 32'd8},
        '{32'd36, 1'b1, 5'd9,  32'd5,        1'b0, 32'd0,  32'd0},
        '{32'd40, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},
        '{32'd52, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},
        '{32'd56, 1'b1, 5'd0,  32'd10,       1'b0, 32'd0,  32'd0},
        '{32'd60, 1'b1, 5'd11, 32'd0,        1'b0, 32'd0,  32'd0},
        '{32'd64, 1'b0, 5'd0,  32'd0,        1'b1, 32'd44, 32'd2},
        '{32'd68, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},
        '{32'd72, 1'b1, 5'd12, 32'd8,        1'b0, 32'd0,  32'd0},
        '{32'd76, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},
        '{32'd76, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0}
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 1:          return "R2";
            2:             return "R4 R10";
            3, 4, 5:       return "R4";
            6, 7:          return "R5";
            8, 16:         return "R3";
            9:             return "R2 R10";
            10, 11, 17, 18: return "R7";
            12, 13:        return "R8";
            14:            return "R6";
            default:       return "R9";
        endcase
    endfunction

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pre_we = 1'b0;
    logic              pre_dmem = 1'b0;
    logic [MEM_AW-1:0] pre_addr = '0;
    logic [31:0]       pre_data = '0;
    logic [31:0]       pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]        rf_waddr_o;
    logic              rf_we_o, dm_we_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    sc_core #(.MEM_AW(MEM_AW)) dut (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_dmem(pre_dmem),
        .pre_addr(pre_addr), .pre_data(pre_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_word(input logic sel, input int idx, input logic [31:0] val);
        @(negedge clk);
        pre_we   = 1'b1;
        pre_dmem = sel;
        pre_addr = idx[MEM_AW-1:0];
        pre_data = val;
    endtask

    task automatic chk_row(input int i);
        string t;
        t = row_tag(i);
        chk(t, "pc", pc_o, ROWS[i].pc);
        chk(t, "rf_we", {31'd0, rf_we_o}, {31'd0, ROWS[i].rfwe});
        if (ROWS[i].rfwe) begin
            chk(t, "rf_waddr", {27'd0, rf_waddr_o}, {27'd0, ROWS[i].wa});
            chk(t, "rf_wdata", rf_wdata_o, ROWS[i].wd);
        end
        chk(t, "dm_we", {31'd0, dm_we_o}, {31'd0, ROWS[i].dmwe});
        if (ROWS[i].dmwe) begin
            chk(t, "dm_addr", dm_addr_o, ROWS[i].da);
            chk(t, "dm_wdata", dm_wdata_o, ROWS[i].dd);
        end
    endtask

    initial begin
        for (int i = 0; i < NPROG; i++) load_word(1'b0, i, PROG[i]);
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'hFFFFFFFD);
        load_word(1'b1, 2, 32'd7);
        @(negedge clk);
        pre_we = 1'b0;
        @(negedge clk);
        #1;
        // R1: state while held in reset
        chk("R1", "pc in reset", pc_o, 32'd0);
        chk("R1", "rf_we in reset", {31'd0, rf_we_o}, 32'd0);
        chk("R1", "dm_we in reset", {31'd0, dm_we_o}, 32'd0);

        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int i = 0; i < NROW; i++) begin
            chk_row(i);
            @(negedge clk);
            #1;
        end

        // R1: reset in mid-run returns to PC 0; skipped store left word 0 intact
        rst = 1'b1;
        #1;
        chk("R1", "rf_we gated", {31'd0, rf_we_o}, 32'd0);
        @(negedge clk);
        #1;
        chk("R1", "pc after reset", pc_o, 32'd0);
        rst = 1'b0;
        #1;
        chk("R1 R7", "restart load value", rf_wdata_o, 32'd5);
        @(negedge clk);
        #1;
        chk("R1", "pc after restart", pc_o, 32'd4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule